// File: doc/BRIEF.md
# Return-Address Stack Sequencer

This block moves single bytes and 16-bit return addresses between a processor core and a stack that lives in an 8-bit-addressed internal RAM. It accepts four commands: push a byte, pop a byte, call, and return. It owns the stack pointer and drives the RAM address, write data and write enable. It reads the RAM through a combinational read port. The RAM array, instruction decode and any interrupt bookkeeping sit outside the block.

A call takes a ready-made return address from the core on `cmd_data`. For a 3-byte long call, that is the address of the call plus 3. The block stores it as two bytes. A return rebuilds the address from two pops and presents it on `ret_addr_o`. Return-from-interrupt uses the same return command, because it restores the address in exactly the same way. Each RAM access takes one clock cycle. `done` pulses once, in the cycle after the last access. A command is taken only while the block is idle.

Top module: `rstk_seq`

## Requirements
- R1: After a synchronous reset, `sp_o` is 0x07, and `done`, `ram_we` and `busy` are all low.
- R2: A push (`cmd_op` = 2'b00) first advances the stack pointer by one. It then writes `cmd_data[7:0]` to RAM at that new pointer value.
- R3: A pop (`cmd_op` = 2'b01) reads the RAM byte at the current pointer and presents it on `pop_data_o`. Only after that read does the pointer drop by one.
- R4: A call (`cmd_op` = 2'b10) performs two pushes in consecutive cycles: `cmd_data[7:0]` at pointer+1, then `cmd_data[15:8]` at pointer+2. The pointer ends 2 higher.
- R5: A return (`cmd_op` = 2'b11) pops twice. The first byte read (at the pointer) becomes `ret_addr_o[15:8]`. The second byte read (at pointer-1) becomes `ret_addr_o[7:0]`. The pointer ends 2 lower.
- R6: The stack pointer wraps modulo 256 in both directions. Incrementing 0xFF gives 0x00, and decrementing 0x00 gives 0xFF. This applies inside two-byte calls and returns too.
- R7: `done` is high for exactly one cycle. Counting negative clock edges from the one where the command is driven, it is seen at the 2nd edge after a push or pop and at the 3rd edge after a call or return. Results and the new pointer are valid when `done` is seen.
- R8: A command presented while `busy` is high has no effect. It changes neither the RAM, nor the pointer, nor the command under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command request, taken only when idle |
| cmd_op | input | 2 | 00 push, 01 pop, 10 call, 11 return |
| cmd_data | input | 16 | Byte to push in bits 7:0, or return address for a call |
| ram_rdata | input | 8 | RAM read data at `ram_addr` (combinational read) |
| ram_addr | output | 8 | RAM address, registered |
| ram_wdata | output | 8 | RAM write data, registered |
| ram_we | output | 1 | RAM write enable, registered |
| sp_o | output | 8 | Current stack pointer |
| pop_data_o | output | 8 | Byte returned by the last pop |
| ret_addr_o | output | 16 | Address restored by the last return |
| busy | output | 1 | High while a command is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two situations are hard to reach from the ports. The first is a two-byte call or return that straddles the pointer wrap. The bench gets there by popping past 0x00 to set the pointer to 0xFF, then runs a call and a return so that their two accesses fall on 0x00 and 0x01. The second is a command arriving mid-operation. The bench holds `cmd_valid` high and changes `cmd_op` while a call is running. It then checks that the pointer and RAM show only the call, and that nothing starts after `done`.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_CALL = 2'b10,
    OP_RET  = 2'b11
  } rstk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WR_END  = 3'd1,
    ST_RD_END  = 3'd2,
    ST_CALL_HI = 3'd3,
    ST_RET_HI  = 3'd4,
    ST_RET_LO  = 3'd5
  } rstk_st_e;

  typedef enum logic [1:0] {
    AS_HOLD = 2'd0,
    AS_SP   = 2'd1,
    AS_INC  = 2'd2,
    AS_DEC  = 2'd3
  } rstk_asel_e;

  typedef enum logic [1:0] {
    WS_NONE  = 2'd0,
    WS_CMD   = 2'd1,
    WS_SAVED = 2'd2
  } rstk_wsel_e;

  typedef enum logic [1:0] {
    CP_NONE = 2'd0,
    CP_POP  = 2'd1,
    CP_HI   = 2'd2,
    CP_RET  = 2'd3
  } rstk_cap_e;

  typedef struct packed {
    logic       sp_inc;
    logic       sp_dec;
    rstk_asel_e asel;
    rstk_wsel_e wsel;
    rstk_cap_e  cap;
    logic       fin;
  } rstk_ctl_t;

endpackage

// File: rtl/rstk_sp.sv
module rstk_sp #(
  parameter int               SPW      = 8,
  parameter logic [SPW-1:0]   RESET_SP = 8'h07
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           inc,
  input  logic           dec,
  output logic [SPW-1:0] sp,
  output logic [SPW-1:0] sp_up,
  output logic [SPW-1:0] sp_dn
);

  localparam logic [SPW-1:0] ONE = {{(SPW-1){1'b0}}, 1'b1};

  assign sp_up = sp + ONE;
  assign sp_dn = sp - ONE;

  always_ff @(posedge clk) begin
    if (rst)      sp <= RESET_SP;
    else if (inc) sp <= sp_up;
    else if (dec) sp <= sp_dn;
  end

  // R6: pointer moves by at most one step per cycle, wrapping modulo 2^SPW
  a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
    (sp == $past(sp)) || (sp == $past(sp) + ONE) || (sp == $past(sp) - ONE));

  // R6: never asked to move both ways at once
  a_r6_no_conflict: assert property (@(posedge clk) disable iff (rst)
    !(inc && dec));

endmodule

// File: rtl/rstk_fsm.sv
module rstk_fsm
  import rstk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cmd_valid,
  input  logic [1:0] cmd_op,
  output rstk_ctl_t ctl,
  output logic      busy
);

  rstk_st_e st, st_nx;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

  assign busy = (st != ST_IDLE);

  always_comb begin
    ctl   = '0;
    st_nx = st;
    unique case (st)
      ST_IDLE: begin
        if (cmd_valid) begin
          unique case (rstk_op_e'(cmd_op))
            OP_PUSH: begin
              ctl.sp_inc = 1'b1;
              ctl.asel   = AS_INC;
              ctl.wsel   = WS_CMD;
              st_nx      = ST_WR_END;
            end
            OP_POP: begin
              ctl.asel = AS_SP;
              st_nx    = ST_RD_END;
            end
            OP_CALL: begin
              ctl.sp_inc = 1'b1;
              ctl.asel   = AS_INC;
              ctl.wsel   = WS_CMD;
              st_nx      = ST_CALL_HI;
            end
            OP_RET: begin
              ctl.asel = AS_SP;
              st_nx    = ST_RET_HI;
            end
            default: st_nx = ST_IDLE;
          endcase
        end
      end
      ST_CALL_HI: begin
        ctl.sp_inc = 1'b1;
        ctl.asel   = AS_INC;
        ctl.wsel   = WS_SAVED;
        st_nx      = ST_WR_END;
      end
      ST_WR_END: begin
        ctl.fin = 1'b1;
        st_nx   = ST_IDLE;
      end
      ST_RD_END: begin
        ctl.cap    = CP_POP;
        ctl.sp_dec = 1'b1;
        ctl.fin    = 1'b1;
        st_nx      = ST_IDLE;
      end
      ST_RET_HI: begin
        ctl.cap    = CP_HI;
        ctl.sp_dec = 1'b1;
        ctl.asel   = AS_DEC;
        st_nx      = ST_RET_LO;
      end
      ST_RET_LO: begin
        ctl.cap    = CP_RET;
        ctl.sp_dec = 1'b1;
        ctl.fin    = 1'b1;
        st_nx      = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  // R4: second half of a call always directly follows acceptance
  a_r4_call_hi_follows_idle: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CALL_HI) |-> ($past(st) == ST_IDLE));

  // R5: the low-byte read of a return always directly follows the high-byte read
  a_r5_ret_order: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RET_LO) |-> ($past(st) == ST_RET_HI));

  // R8: a busy state never jumps straight into a new command's states
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && (st != ST_CALL_HI) && (st != ST_RET_HI)) |=> !busy);

endmodule

// File: rtl/rstk_dp.sv
module rstk_dp
  import rstk_pkg::*;
#(
  parameter int DW  = 8,
  parameter int SPW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  rstk_ctl_t       ctl,
  input  logic [SPW-1:0]  sp,
  input  logic [SPW-1:0]  sp_up,
  input  logic [SPW-1:0]  sp_dn,
  input  logic [2*DW-1:0] cmd_data,
  input  logic [DW-1:0]   ram_rdata,
  output logic [SPW-1:0]  ram_addr,
  output logic [DW-1:0]   ram_wdata,
  output logic            ram_we,
  output logic [DW-1:0]   pop_data,
  output logic [2*DW-1:0] ret_addr,
  output logic            done
);

  logic [DW-1:0] hi_saved;
  logic [DW-1:0] hi_read;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr  <= '0;
      ram_wdata <= '0;
      ram_we    <= 1'b0;
      hi_saved  <= '0;
      hi_read   <= '0;
      pop_data  <= '0;
      ret_addr  <= '0;
      done      <= 1'b0;
    end else begin
      done <= ctl.fin;

      unique case (ctl.asel)
        AS_SP:   ram_addr <= sp;
        AS_INC:  ram_addr <= sp_up;
        AS_DEC:  ram_addr <= sp_dn;
        default: ram_addr <= ram_addr;
      endcase

      unique case (ctl.wsel)
        WS_CMD: begin
          ram_wdata <= cmd_data[DW-1:0];
          hi_saved  <= cmd_data[2*DW-1:DW];
          ram_we    <= 1'b1;
        end
        WS_SAVED: begin
          ram_wdata <= hi_saved;
          ram_we    <= 1'b1;
        end
        default: ram_we <= 1'b0;
      endcase

      unique case (ctl.cap)
        CP_POP:  pop_data <= ram_rdata;
        CP_HI:   hi_read  <= ram_rdata;
        CP_RET:  ret_addr <= {hi_read, ram_rdata};
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rstk_seq.sv
module rstk_seq
  import rstk_pkg::*;
#(
  parameter int             DW       = 8,
  parameter int             SPW      = 8,
  parameter logic [SPW-1:0] RESET_SP = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [2*DW-1:0] cmd_data,
  input  logic [DW-1:0]   ram_rdata,
  output logic [SPW-1:0]  ram_addr,
  output logic [DW-1:0]   ram_wdata,
  output logic            ram_we,
  output logic [SPW-1:0]  sp_o,
  output logic [DW-1:0]   pop_data_o,
  output logic [2*DW-1:0] ret_addr_o,
  output logic            busy,
  output logic            done
);

  rstk_ctl_t      ctl;
  logic [SPW-1:0] sp_up, sp_dn;

  rstk_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .ctl       (ctl),
    .busy      (busy)
  );

  rstk_sp #(.SPW(SPW), .RESET_SP(RESET_SP)) u_sp (
    .clk   (clk),
    .rst   (rst),
    .inc   (ctl.sp_inc),
    .dec   (ctl.sp_dec),
    .sp    (sp_o),
    .sp_up (sp_up),
    .sp_dn (sp_dn)
  );

  rstk_dp #(.DW(DW), .SPW(SPW)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .sp        (sp_o),
    .sp_up     (sp_up),
    .sp_dn     (sp_dn),
    .cmd_data  (cmd_data),
    .ram_rdata (ram_rdata),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_we    (ram_we),
    .pop_data  (pop_data_o),
    .ret_addr  (ret_addr_o),
    .done      (done)
  );

  // R2: every write lands at the already-advanced pointer
  a_r2_write_at_sp: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr == sp_o));

  // R4: back-to-back writes of a call use ascending addresses
  a_r4_call_ascending: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + 1'b1));

  // R7: completion is a single-cycle pulse that follows activity
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  // R8: writes only happen inside an operation
  a_r8_we_only_busy: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy);

endmodule

// File: tb/rstk_seq_tb.sv
module rstk_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [15:0] cmd_data = '0;
  logic [7:0]  ram_rdata;
  logic [7:0]  ram_addr, ram_wdata, sp_o, pop_data_o;
  logic        ram_we, busy, done;
  logic [15:0] ret_addr_o;

  logic [7:0] mem [256];

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  rstk_seq u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .ram_rdata(ram_rdata), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_we(ram_we), .sp_o(sp_o),
    .pop_data_o(pop_data_o), .ret_addr_o(ret_addr_o), .busy(busy), .done(done)
  );

  always_ff @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
  assign ram_rdata = mem[ram_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [15:0] arg, output int lat);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // {op, arg, expected sp, expected result}
  localparam logic [41:0] VEC [8] = '{
    {2'b00, 16'h00A5, 8'h08, 16'h00A5},
    {2'b10, 16'h1234, 8'h0A, 16'h1234},
    {2'b00, 16'h005C, 8'h0B, 16'h005C},
    {2'b01, 16'h0000, 8'h0A, 16'h005C},
    {2'b11, 16'h0000, 8'h08, 16'h1234},
    {2'b01, 16'h0000, 8'h07, 16'h00A5},
    {2'b10, 16'hBEEF, 8'h09, 16'hBEEF},
    {2'b11, 16'h0000, 8'h07, 16'hBEEF}
  };

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int lat;
    logic [7:0] below;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    // R1 reset state
    do_reset();
    chk("R1 sp", sp_o, 8'h07);
    chk("R1 done", done, 0);
    chk("R1 we", ram_we, 0);
    chk("R1 busy", busy, 0);

    // Table walk: R2 R3 R4 R5 R7
    for (int i = 0; i < 8; i++) begin
      logic [1:0]  op;
      logic [15:0] arg, res;
      logic [7:0]  xsp;
      {op, arg, xsp, res} = VEC[i];
      issue(op, arg, lat);
      chk("R7 latency", lat, (op[1] ? 3 : 2));
      chk("R2/R3/R4/R5 sp", sp_o, xsp);
      below = sp_o - 8'd1;
      case (op)
        2'b00: chk("R2 pushed byte", mem[sp_o], res);
        2'b01: chk("R3 popped byte", pop_data_o, res);
        2'b10: chk("R4 call bytes", {mem[sp_o], mem[below]}, res);
        default: chk("R5 return addr", ret_addr_o, res);
      endcase
      @(negedge clk);
      chk("R7 done one cycle", done, 0);
    end

    // R6 wrap: pop below 0x00, then push back up
    do_reset();
    for (int k = 0; k < 8; k++) issue(2'b01, 16'h0, lat);
    chk("R6 wrap down", sp_o, 8'hFF);
    issue(2'b00, 16'h003C, lat);
    chk("R6 wrap up", sp_o, 8'h00);
    chk("R6 push at 00", mem[8'h00], 8'h3C);
    issue(2'b01, 16'h0, lat);
    chk("R6 pop at 00", pop_data_o, 8'h3C);
    chk("R6 sp after pop", sp_o, 8'hFF);
    issue(2'b10, 16'hCAFE, lat);
    chk("R6 call lo at 00", mem[8'h00], 8'hFE);
    chk("R6 call hi at 01", mem[8'h01], 8'hCA);
    chk("R6 call sp", sp_o, 8'h01);
    issue(2'b11, 16'h0, lat);
    chk("R6 ret across wrap", ret_addr_o, 16'hCAFE);
    chk("R6 ret sp", sp_o, 8'hFF);

    // R8 commands while busy are ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_data = 16'h1357;
    @(negedge clk);
    chk("R8 busy", busy, 1);
    cmd_op = 2'b00; cmd_data = 16'h0077;
    @(negedge clk);
    cmd_op = 2'b11;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8 done", done, 1);
    chk("R8 sp", sp_o, 8'h01);
    chk("R8 lo kept", mem[8'h00], 8'h57);
    chk("R8 hi kept", mem[8'h01], 8'h13);
    @(negedge clk);
    chk("R8 idle after", busy, 0);
    chk("R8 sp unchanged", sp_o, 8'h01);
    chk("R8 no stray write", mem[8'h02], 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule